// File: doc/BRIEF.md
# Three-Lane 7:1 Parallel Serializer

This block takes a 21-bit parallel word once per word period and sends it out over three serial lanes. Each lane carries seven bits per word. A fourth lane carries a fixed seven-slot clock pattern, so a receiver can find word boundaries without a separate framing channel. The block runs on a bit-rate clock at seven times the word rate. An outside strobe, `load`, is high for one bit-clock cycle per word and marks the rising edge of the word clock. Any clock multiplier sits outside the block.

An active-low power-down input clears every register at once and turns the output drivers off. The `drv_en` output is the pad driver enable. While it is low, every lane value is forced to 0, which stands in for a high-impedance pad. After power-down is released, a lock-wait counter runs for a parameterised number of bit clocks, which covers the settling time of an outside clock multiplier. The drivers then switch on at the next word boundary.

Top module: `lane7_serializer`

## Requirements
- R1: `par_in` is sampled only on a `bit_clk` rising edge where `load` is 1. Its value on any other edge has no effect on the lanes.
- R2: The lane mapping is fixed. `lane_out[0]` carries word bits 6..0, `lane_out[1]` carries bits 13..7, and `lane_out[2]` carries bits 20..14.
- R3: In the first bit period after a `load` edge, each lane sends the highest-index bit of its group. The following periods go in descending index order, so the lowest-index bit goes out in the seventh period.
- R4: A word captured at `load` edge k is sent during the seven bit periods that follow `load` edge k+1, which is one word of latency.
- R5: While enabled, `fclk_out` sends the slots 1,1,0,0,0,1,1 over the seven bit periods after each `load` edge, first slot first. Each frame therefore holds exactly one rising edge.
- R6: While `pd_n` is 0, `drv_en`, `lane_out` and `fclk_out` are 0. This takes effect without waiting for a clock edge, and all internal state is cleared.
- R7: After `pd_n` goes to 1, `drv_en` stays 0 for at least `LOCK_CYCLES` bit clocks. It rises on the first `load` edge after that and stays 1 until the next power-down. While `drv_en` is 0, all lane outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-rate clock, seven times the word rate |
| pd_n | input | 1 | Active-low power-down and asynchronous reset |
| load | input | 1 | One-cycle word strobe, marks the word-clock rising edge |
| par_in | input | 21 | Parallel word to serialise |
| lane_out | output | 3 | Serial data lanes, highest bit of each group first |
| fclk_out | output | 1 | Forwarded clock lane carrying the frame pattern |
| drv_en | output | 1 | Output driver enable; the lanes are 0 while it is low |

## Verification
The stimulus sweeps a walking one and a walking zero across all 21 input positions. A misrouted lane or a reversed slot order in any group then shows up as one wrong recovered bit. All-zero, all-ones and the two alternating words follow; they tell a stuck lane apart from a swap between neighbouring slots. A long pseudo-random run comes last. Between strobes the bench drives the inverted word, so that any sampling outside a `load` edge corrupts the recovered frame. The bench deserialises the three lanes by locating the forwarded clock pattern, so frame spacing and alignment are tested together with the data. Power-down is asserted in the middle of a word and released again, which tests the asynchronous clear and a second lock wait.

// File: rtl/lane7_serializer.sv
module lane7_serializer #(
  parameter int LANES = 3,
  parameter int SLOTS = 7,
  parameter logic [SLOTS-1:0] FCLK_PATTERN = 7'b1100011,
  parameter int LOCK_CYCLES = 5250000
) (
  input  logic                   bit_clk,
  input  logic                   pd_n,
  input  logic                   load,
  input  logic [LANES*SLOTS-1:0] par_in,
  output logic [LANES-1:0]       lane_out,
  output logic                   fclk_out,
  output logic                   drv_en
);

  localparam int WORD_W = LANES * SLOTS;
  localparam int CNT_W  = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES);

  logic [WORD_W-1:0] cap_q;
  logic [SLOTS-1:0]  fpat_q;
  logic [CNT_W-1:0]  wait_q;
  logic              locked;

  assign locked = (wait_q == LOCK_LAST);

  always_ff @(posedge bit_clk or negedge pd_n) begin
    if (!pd_n) begin
      cap_q  <= '0;
      fpat_q <= '0;
      wait_q <= '0;
      drv_en <= 1'b0;
    end else begin
      if (load)
        cap_q <= par_in;
      fpat_q <= load ? FCLK_PATTERN : {fpat_q[SLOTS-2:0], 1'b0};
      if (!locked)
        wait_q <= wait_q + 1'b1;
      if (load && locked)
        drv_en <= 1'b1;
    end
  end

  assign fclk_out = drv_en & fpat_q[SLOTS-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] sh_q;

    always_ff @(posedge bit_clk or negedge pd_n) begin
      if (!pd_n)
        sh_q <= '0;
      else if (load)
        sh_q <= cap_q[l*SLOTS +: SLOTS];
      else
        sh_q <= {sh_q[SLOTS-2:0], 1'b0};
    end

    assign lane_out[l] = drv_en & sh_q[SLOTS-1];
  end

endmodule

// File: rtl/lane7_serializer_chk.sv
module lane7_serializer_chk #(
  parameter int LANES = 3,
  parameter int SLOTS = 7,
  parameter int LOCK_CYCLES = 5250000
) (
  input logic                   bit_clk,
  input logic                   pd_n,
  input logic                   load,
  input logic [LANES*SLOTS-1:0] par_in,
  input logic [LANES-1:0]       lane_out,
  input logic                   fclk_out,
  input logic                   drv_en
);

  localparam int WORD_W = LANES * SLOTS;
  localparam int CNT_W  = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES);

  logic [WORD_W-1:0] hold_q, send_q;
  logic [CNT_W-1:0]  seen_q;
  logic [LANES-1:0]  head;

  always_ff @(posedge bit_clk or negedge pd_n) begin
    if (!pd_n) begin
      hold_q <= '0;
      send_q <= '0;
      seen_q <= '0;
    end else begin
      if (load) begin
        hold_q <= par_in;
        send_q <= hold_q;
      end
      if (seen_q != LOCK_LAST)
        seen_q <= seen_q + 1'b1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_head
    assign head[l] = send_q[l*SLOTS + SLOTS - 1];
  end

  // R6
  pd_quiet_chk: assert property (@(posedge bit_clk)
    !pd_n |-> (!drv_en && lane_out == '0 && !fclk_out));

  // R7
  lock_wait_chk: assert property (@(posedge bit_clk) disable iff (!pd_n)
    $rose(drv_en) |-> (seen_q == LOCK_LAST && $past(load)));

  // R7
  enable_hold_chk: assert property (@(posedge bit_clk) disable iff (!pd_n)
    $past(drv_en) |-> drv_en);

  // R5
  fclk_mark_chk: assert property (@(posedge bit_clk) disable iff (!pd_n)
    ($past(load) && drv_en) |-> fclk_out);

  // R4
  first_bit_chk: assert property (@(posedge bit_clk) disable iff (!pd_n)
    ($past(load) && drv_en) |-> (lane_out == head));

endmodule

bind lane7_serializer lane7_serializer_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .bit_clk(bit_clk), .pd_n(pd_n), .load(load), .par_in(par_in),
  .lane_out(lane_out), .fclk_out(fclk_out), .drv_en(drv_en)
);

// File: tb/sim_lane7_serializer.sv
module sim_lane7_serializer;
  localparam int LOCK = 40;
  localparam logic [6:0] MARK = 7'b1100011;

  logic        clk = 1'b0;
  logic        pd_n = 1'b1;
  logic        load = 1'b0;
  logic [20:0] par_in = '0;
  logic [2:0]  lane_out;
  logic        fclk_out;
  logic        drv_en;

  always #4 clk = ~clk;

  lane7_serializer #(.LOCK_CYCLES(LOCK)) u0 (
    .bit_clk(clk), .pd_n(pd_n), .load(load), .par_in(par_in),
    .lane_out(lane_out), .fclk_out(fclk_out), .drv_en(drv_en)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [20:0] words [0:4095];
  int nw = 0;
  int ph = 0;
  logic [20:0] lfsr = 21'h1ACE5;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] pick(input int n, input logic [20:0] rnd);
    int k = n % 70;
    if (k < 21) return 21'd1 << k;
    if (k < 42) return ~(21'd1 << (k - 21));
    if (k == 42) return 21'h000000;
    if (k == 43) return 21'h1FFFFF;
    if (k == 44) return 21'h155555;
    if (k == 45) return 21'h0AAAAA;
    return rnd;
  endfunction

  task automatic run(input int cycles);
    int edges = 0;
    int first_en = -1;
    int exp_idx = 0;
    int last_hit = -1;
    int frames = 0;
    logic [6:0] h0 = '0, h1 = '0, h2 = '0, hf = '0;
    logic [20:0] rec, w;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      edges++;
      if (drv_en) begin
        if (first_en < 0) begin
          first_en = edges;
          // R7: enable after the lock wait, on a word boundary
          chk(edges >= LOCK + 1 && edges <= LOCK + 7, "R7 enable delay", edges, LOCK + 1);
          exp_idx = nw - 2;
        end
        h0 = {h0[5:0], lane_out[0]};
        h1 = {h1[5:0], lane_out[1]};
        h2 = {h2[5:0], lane_out[2]};
        hf = {hf[5:0], fclk_out};
        if (hf == MARK) begin
          rec = {h2, h1, h0};
          // R1 R2 R3 R4: lane, position and latency of every bit
          chk(rec == words[exp_idx], "R1/R2/R3/R4 recovered word", rec, words[exp_idx]);
          exp_idx++;
          if (last_hit >= 0)
            chk(edges - last_hit == 7, "R5 frame spacing", edges - last_hit, 7);
          last_hit = edges;
          frames++;
        end
      end else begin
        // R7: lanes quiet during lock wait
        chk(lane_out == 3'b000 && fclk_out == 1'b0, "R7 idle outputs", {lane_out, fclk_out}, 0);
        h0 = '0; h1 = '0; h2 = '0; hf = '0;
      end
      if (ph == 0) begin
        lfsr = {lfsr[19:0], lfsr[20] ^ lfsr[18]};
        w = pick(nw, lfsr);
        words[nw] = w;
        nw++;
        load = 1'b1;
        par_in = w;
      end else begin
        load = 1'b0;
        par_in = ~words[nw-1];
      end
      ph = (ph + 1) % 7;
    end
    // R5: one frame marker per word once enabled
    chk(frames >= (cycles - LOCK - 20) / 7, "R5 frame count", frames, (cycles - LOCK - 20) / 7);
  endtask

  initial begin
    #2 pd_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      // R6: reset state
      chk(!drv_en && lane_out == 3'b000 && !fclk_out, "R6 reset state", {drv_en, lane_out, fclk_out}, 0);
    end
    pd_n = 1'b1;
    run(160 * 7);
    @(posedge clk);
    #1 pd_n = 1'b0;
    load = 1'b0;
    #1;
    // R6: asynchronous shutdown in mid-word
    chk(!drv_en && lane_out == 3'b000 && !fclk_out, "R6 async power-down", {drv_en, lane_out, fclk_out}, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!drv_en && lane_out == 3'b000 && !fclk_out, "R6 held power-down", {drv_en, lane_out, fclk_out}, 0);
    end
    pd_n = 1'b1;
    run(90 * 7);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule